// File: doc/BRIEF.md
# Keyboard Matrix and Peripheral Port Glue

This block is the system-side wiring behind a three-register parallel I/O interface. It holds an active-low key matrix that key press and release events update. It turns the value written to the control-output register into a keyboard row select, two cassette lines and two bus-control lines for a sound generator. When the CPU reads the status register, it builds the status byte from the vertical sync and the cassette input.

The CPU reaches the block through a plain I/O strobe interface. The block is addressed when one address bit is low, and two further address bits pick the register. The sound generator sees three things: a data byte written by the CPU, the two bus-control lines, and the byte of the selected keyboard row. That row byte follows the matrix continuously, so a key change shows up without any rewrite of the row select. The sound generator and the cassette mechanism are outside this block.

Top module: `kbd_port_glue`

## Requirements
- R1: After reset every matrix bit is 1, the latched control-output and data-output registers are 0, and so `snd_port_in` reads 0xFF and `tape_motor`, `tape_out`, `snd_bdir`, `snd_bc1` and `snd_wdata` are all 0.
- R2: A key event with `key_valid` high takes its row from `key_code[7:4]` and its column from `key_code[2:0]`. `key_code[3]` is ignored. A press clears that matrix bit and a release sets it, and the change is visible one clock later. Events whose row is 10 or higher change nothing.
- R3: `snd_port_in` shows the matrix row picked by bits 3:0 of the latched control-output register when that value is below 10, and 0xFF otherwise. It follows matrix changes without a new register write.
- R4: `tape_motor` equals bit 4 and `tape_out` equals bit 5 of the latched control-output register.
- R5: `snd_bdir` equals bit 7 and `snd_bc1` equals bit 6 of the latched control-output register.
- R6: A read of register 1 returns `{tape_in, 6'b111111, vsync}`, which puts vsync on bit 0 and the cassette input on bit 7.
- R7: A write to register 0 latches the written byte onto `snd_wdata`. A read of register 0 returns `snd_rdata`.
- R8: The block is selected only when `io_addr[11]` is 0, and `io_addr[9:8]` picks the register (0 data, 1 status, 2 control output, 3 unused). A write is latched at the next clock edge only to register 0 or 2 of a selected access. All other writes change no output.
- R9: `io_rdata` is 0xFF when `io_rd` is low, when the address is not selected, or when register 2 or 3 is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | Key event strobe |
| key_press | input | 1 | 1 = press, 0 = release |
| key_code | input | 8 | Row in bits 7:4, column in bits 2:0 |
| io_addr | input | 16 | CPU I/O address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational) |
| snd_rdata | input | 8 | Data output of the sound generator |
| snd_wdata | output | 8 | Latched data for the sound generator bus |
| snd_bdir | output | 1 | Sound generator bus direction line |
| snd_bc1 | output | 1 | Sound generator bus control line |
| snd_port_in | output | 8 | Selected keyboard row for the sound generator input port |
| tape_motor | output | 1 | Cassette motor control |
| tape_out | output | 1 | Cassette output level |
| tape_in | input | 1 | Cassette input level |
| vsync | input | 1 | Vertical sync status |

## Verification
Reads are combinational, so the bench drives a read on a falling edge and samples `io_rdata` a nanosecond later, in the same cycle. Writes and key events are registered once: the bench drives them on one falling edge, withdraws them on the next, and samples the effect after that rising edge. The row byte on `snd_port_in` is compared against a bench-side matrix model after every key event in a sweep of all 80 positions. All 256 control-output values are swept as well. Writes with bad addresses and key events with bad rows are each followed by a read-back of every output they could have touched.

// File: rtl/kbd_port_glue.sv
module kbd_port_glue #(
  parameter int ROWS    = 10,
  parameter int COLS    = 8,
  parameter int SEL_BIT = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_valid,
  input  logic        key_press,
  input  logic [7:0]  key_code,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic [7:0]  snd_rdata,
  output logic [7:0]  snd_wdata,
  output logic        snd_bdir,
  output logic        snd_bc1,
  output logic [COLS-1:0] snd_port_in,
  output logic        tape_motor,
  output logic        tape_out,
  input  logic        tape_in,
  input  logic        vsync
);
  localparam int CW = $clog2(COLS);

  logic [ROWS-1:0][COLS-1:0] mtx;
  logic [7:0] ctl_q, dat_q;
  logic [3:0] key_row;
  logic [CW-1:0] key_col;
  logic       sel;
  logic [1:0] regno;
  logic [3:0] row_sel;

  assign key_row = key_code[7:4];
  assign key_col = key_code[CW-1:0];
  assign sel     = ~io_addr[SEL_BIT];
  assign regno   = io_addr[9:8];
  assign row_sel = ctl_q[3:0];

  // one register row per matrix line
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n)
        mtx[r] <= '1;
      else if (key_valid && key_row == 4'(r))
        mtx[r][key_col] <= ~key_press;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      dat_q <= '0;
    end else if (io_wr && sel) begin
      if (regno == 2'd0) dat_q <= io_wdata;
      if (regno == 2'd2) ctl_q <= io_wdata;
    end
  end

  assign snd_port_in = (int'(row_sel) < ROWS) ? mtx[row_sel] : '1;
  assign tape_motor  = ctl_q[4];
  assign tape_out    = ctl_q[5];
  assign snd_bc1     = ctl_q[6];
  assign snd_bdir    = ctl_q[7];
  assign snd_wdata   = dat_q;

  always_comb begin
    io_rdata = 8'hFF;
    if (io_rd && sel) begin
      case (regno)
        2'd0:    io_rdata = snd_rdata;
        2'd1:    io_rdata = {tape_in, 6'b111111, vsync};
        default: io_rdata = 8'hFF;
      endcase
    end
  end

  a_r2_key_update: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && int'(key_row) < ROWS) |=>
      mtx[$past(key_row)][$past(key_col)] == ~$past(key_press));

  a_r2_bad_row: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && int'(key_row) >= ROWS) |=> $stable(mtx));

  a_r4_ctl_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_addr[SEL_BIT] && io_addr[9:8] == 2'd2) |=>
      (tape_motor == $past(io_wdata[4]) && snd_bdir == $past(io_wdata[7])));

  a_r7_data_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_addr[SEL_BIT] && io_addr[9:8] == 2'd0) |=> snd_wdata == $past(io_wdata));

  a_r8_unsel_write: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr[SEL_BIT]) |=> ($stable(snd_wdata) && $stable(ctl_q)));

  a_r9_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> io_rdata == 8'hFF);
endmodule

// File: tb/kbd_port_glue_tb.sv
module kbd_port_glue_tb_top;
  logic clk = 0, rst_n = 0;
  logic key_valid = 0, key_press = 0;
  logic [7:0] key_code = 0;
  logic [15:0] io_addr = 16'h0800;
  logic io_wr = 0, io_rd = 0, tape_in = 0, vsync = 0;
  logic [7:0] io_wdata = 0, snd_rdata = 0;
  logic [7:0] io_rdata, snd_wdata, snd_port_in;
  logic snd_bdir, snd_bc1, tape_motor, tape_out;
  int nchk = 0, nfail = 0;
  logic [7:0] model [10];

  always #5ns clk = ~clk;

  kbd_port_glue dut_i (.clk, .rst_n, .key_valid, .key_press, .key_code, .io_addr,
    .io_wr, .io_rd, .io_wdata, .io_rdata, .snd_rdata, .snd_wdata, .snd_bdir,
    .snd_bc1, .snd_port_in, .tape_motor, .tape_out, .tape_in, .vsync);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0; io_addr = 16'h0800;
  endtask

  task automatic key(input logic [7:0] c, input logic p);
    @(negedge clk); key_code = c; key_press = p; key_valid = 1;
    @(negedge clk); key_valid = 0;
    if (c[7:4] < 10) model[c[7:4]][c[2:0]] = ~p;
  endtask

  function automatic logic [7:0] exp_row(input logic [3:0] s);
    return (s < 10) ? model[s] : 8'hFF;
  endfunction

  task automatic check_rows(input string req);
    for (int r = 0; r < 16; r++) begin
      wr(16'h0200, 8'(r));
      check(req, snd_port_in, exp_row(4'(r)));
    end
  endtask

  initial begin
    #2_000_000ns;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int r = 0; r < 10; r++) model[r] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 port_in", snd_port_in, 8'hFF);
    check("R1 ctl", {tape_motor, tape_out, snd_bdir, snd_bc1}, 4'h0);
    check("R1 wdata", snd_wdata, 8'h00);
    check_rows("R1 rows");

    // R2/R3: press and release every position, row kept selected
    for (int r = 0; r < 10; r++) begin
      wr(16'h0200, 8'(r));
      for (int c = 0; c < 8; c++) begin
        key(8'((r << 4) | c | ((c & 1) << 3)), 1'b1);
        check("R2 press / R3 live row", snd_port_in, model[r]);
      end
      for (int c = 0; c < 8; c += 2) begin
        key(8'((r << 4) | c), 1'b0);
        check("R2 release / R3 live row", snd_port_in, model[r]);
      end
    end
    check_rows("R3 row sweep");
    // R2 bad rows change nothing
    for (int r = 10; r < 16; r++) begin
      key(8'(r << 4), 1'b0);
      key(8'((r << 4) | 5), 1'b1);
    end
    check_rows("R2 bad row");

    // R4/R5: sweep control byte
    for (int v = 0; v < 256; v++) begin
      wr(16'h0200, 8'(v));
      check("R4 motor", tape_motor, 32'((v >> 4) & 1));
      check("R4 tape_out", tape_out, 32'((v >> 5) & 1));
      check("R5 bdir", snd_bdir, 32'((v >> 7) & 1));
      check("R5 bc1", snd_bc1, 32'((v >> 6) & 1));
      check("R3 sel", snd_port_in, exp_row(4'(v)));
    end

    // R6 status read
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); tape_in = k[1]; vsync = k[0]; io_addr = 16'h0100; io_rd = 1;
      #1ns check("R6 status", io_rdata, {k[1], 6'b111111, k[0]});
      io_rd = 0; io_addr = 16'h0800;
    end

    // R7 data write and read
    for (int v = 0; v < 256; v += 17) begin
      wr(16'h0000, 8'(v));
      check("R7 wdata", snd_wdata, 32'(v));
      @(negedge clk); snd_rdata = 8'(v ^ 8'h5A); io_addr = 16'h0000; io_rd = 1;
      #1ns check("R7 rdata", io_rdata, 32'(v ^ 8'h5A));
      io_rd = 0; io_addr = 16'h0800;
    end

    // R8 decode: unselected and non-latching writes
    wr(16'h0000, 8'h3C); wr(16'h0200, 8'h05);
    for (int a = 0; a < 8; a++) begin
      logic [15:0] ad;
      ad = 16'((a[2] << 11) | (a[1:0] << 8));
      if (a[2] || a[1:0] == 2'd1 || a[1:0] == 2'd3) begin
        wr(ad, 8'hF2);
        check("R8 ignored write data", snd_wdata, 8'h3C);
        check("R8 ignored write ctl", {snd_bdir, snd_bc1, tape_out, tape_motor}, 4'h0);
        check("R8 ignored write row", snd_port_in, exp_row(4'h5));
      end
    end
    // R9 read defaults
    snd_rdata = 8'h12; tape_in = 0; vsync = 0;
    for (int a = 0; a < 8; a++) begin
      @(negedge clk); io_addr = 16'((a[2] << 11) | (a[1:0] << 8)); io_rd = 1;
      #1ns
      if (a[2] || a[1:0] >= 2) check("R9 default read", io_rdata, 8'hFF);
      io_rd = 0;
      #1ns check("R9 idle read", io_rdata, 8'hFF);
    end
    io_addr = 16'h0800;

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule